// File: doc/BRIEF.md
# Legacy Interrupt Message Generator

This block sits in the interrupt path of a PCIe endpoint that has two functions. Each function presents one level-style interrupt request. The block turns changes in those requests into virtual-wire messages that raise or lower one of four shared interrupt wires (INTA to INTD). Each function is mapped to a wire by a build-time pin code. Two functions can drive one wire, and in that case the wire carries the OR of their requests. A message goes out only when a wire's aggregate level actually changes.

Each request passes through a registered copy in the message clock domain. That copy is masked by a per-function disable input and by the validity of the function's pin code. Every wire keeps a short record of level changes that have not been sent yet. A round-robin selector moves these changes into a registered valid/ready output slot. Changes on the same wire always leave in the order they happened.

A read-only configuration word per function reports the function's pin code and its interrupt line number. The function is picked with a select input.

Top module: `lim_msg_gen`

## Requirements
- R1: When the OR of the enabled requests mapped to a wire goes from 0 to 1, one message with `msg_kind` = 1 (assert) is issued for that wire.
- R2: When that aggregate goes from 1 to 0, one message with `msg_kind` = 0 (deassert) is issued. While no change is waiting, the last level sent for a wire equals its current aggregate.
- R3: `msg_pin` carries the wire's 3-bit code: 3'b001 = INTA, 3'b010 = INTB, 3'b011 = INTC, 3'b100 = INTD. No other code is ever sent.
- R4: With both functions on one wire, a second request that rises while the wire is already high sends nothing. Deassert is sent only once both requests are clear.
- R5: Functions on separate wires produce independent messages, each tagged with its own code, even when both change in the same cycle.
- R6: A function whose pin code is 3'b000 or above 3'b100 never causes a message.
- R7: While `msg_valid` is high and `msg_ready` is low, `msg_kind` and `msg_pin` hold steady. Changes that occur during a stall are kept and sent later in order of occurrence per wire, so an assert followed by a deassert delivers both.
- R8: Each wire holds up to `PEND_DEPTH` unsent level changes on top of the one in the output slot.
- R9: Raising a function's `irq_dis` removes its contribution. If the wire falls as a result, a deassert is sent. Lowering `irq_dis` again while the request is high sends an assert.
- R10: One cycle after `cfg_sel` selects function f, `cfg_rdata` reads bits [15:11] = 0, bits [10:8] = f's pin code and bits [7:0] = f's line. A line of 8'hFF means not connected, and 0 to 15 name IRQ0 to IRQ15.
- R11: Synchronous reset clears the request copies, wire states and unsent changes, and keeps `msg_valid` low. A request held high across reset release yields an assert afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Message clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NUM_FUNC | Level interrupt request per function |
| irq_dis | input | NUM_FUNC | Interrupt disable per function |
| msg_valid | output | 1 | Message slot holds a message |
| msg_ready | input | 1 | Downstream accepts the message this cycle |
| msg_kind | output | 1 | 1 = assert, 0 = deassert |
| msg_pin | output | 3 | Wire code of the message |
| cfg_sel | input | SEL_W | Function whose configuration word is read |
| cfg_rdata | output | 16 | Registered configuration word |

## Verification
The overflow property assumes the consumer drains messages at least as fast as the requests toggle over any window longer than `PEND_DEPTH` changes. The bench keeps within this by limiting stalled bursts to four changes, and under throttled ready it toggles a request at most every other cycle while ready is high two cycles in three. The hold property assumes the downstream side never takes back a message it has already been offered. The bench changes ready only at falling edges, and a stalled message is either still held or accepted.

// File: rtl/lim_pkg.sv
package lim_pkg;
  localparam int NUM_PINS = 4;
  localparam int PIN_W    = 3;
  localparam int LINE_W   = 8;
  localparam int CFG_W    = 16;

  typedef logic [PIN_W-1:0] pin_code_t;

  typedef enum logic {
    MSG_DEASSERT = 1'b0,
    MSG_ASSERT   = 1'b1
  } msg_kind_t;

  function automatic logic pin_code_ok(input pin_code_t code);
    return (code >= 3'd1) && (code <= 3'd4);
  endfunction

  function automatic pin_code_t idx_to_code(input logic [1:0] idx);
    return pin_code_t'({1'b0, idx}) + 3'd1;
  endfunction
endpackage

// File: rtl/lim_req_stage.sv
module lim_req_stage
  import lim_pkg::*;
#(
  parameter int NUM_FUNC = 2,
  parameter logic [PIN_W*NUM_FUNC-1:0] FUNC_PIN = {3'd1, 3'd1}
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_FUNC-1:0] irq_req,
  input  logic [NUM_FUNC-1:0] irq_dis,
  output logic [NUM_PINS-1:0] pin_lvl
);
  logic [NUM_FUNC-1:0] req_q;

  // Registered, masked copy of each request in the message domain.
  for (genvar f = 0; f < NUM_FUNC; f++) begin : g_func
    localparam pin_code_t CODE = FUNC_PIN[PIN_W*f +: PIN_W];
    localparam logic      LIVE = pin_code_ok(CODE);
    always_ff @(posedge clk) begin
      if (rst) req_q[f] <= 1'b0;
      else     req_q[f] <= irq_req[f] & ~irq_dis[f] & LIVE;
    end
  end

  // Aggregate level per wire: OR of the functions mapped onto it.
  always_comb begin
    pin_lvl = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      for (int f = 0; f < NUM_FUNC; f++) begin
        if (req_q[f] && FUNC_PIN[PIN_W*f +: PIN_W] == idx_to_code(2'(p)))
          pin_lvl[p] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lim_pin_track.sv
module lim_pin_track #(
  parameter int PEND_DEPTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  input  logic pop,
  output logic pend,
  output logic next_kind
);
  localparam int CW = $clog2(PEND_DEPTH + 1);

  logic          wire_q;
  logic          sent_lvl;
  logic [CW-1:0] cnt;
  logic          toggle;

  assign toggle    = lvl ^ wire_q;
  assign pend      = (cnt != '0);
  assign next_kind = ~sent_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      wire_q   <= 1'b0;
      sent_lvl <= 1'b0;
      cnt      <= '0;
    end else begin
      wire_q <= lvl;
      if (pop) sent_lvl <= ~sent_lvl;
      case ({toggle, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R8: a new change must find room in the record
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    (toggle && !pop) |-> (cnt < CW'(PEND_DEPTH)));

  // R2: level last sent plus unsent changes reproduces the wire state
  p_level_track_r2: assert property (@(posedge clk) disable iff (rst)
    (sent_lvl ^ cnt[0]) == wire_q);
endmodule

// File: rtl/lim_msg_out.sv
module lim_msg_out
  import lim_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pend,
  input  logic [NUM_PINS-1:0] kind,
  output logic [NUM_PINS-1:0] pop,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic                msg_kind,
  output pin_code_t           msg_pin
);
  localparam int IDX_W = $clog2(NUM_PINS);

  logic [IDX_W-1:0] ptr;
  logic [IDX_W-1:0] grant;
  logic             any;
  logic             load;

  assign load = !msg_valid || msg_ready;

  // Round-robin pick starting after the last served wire.
  always_comb begin
    logic [IDX_W-1:0] cand;
    grant = '0;
    any   = 1'b0;
    for (int i = 0; i < NUM_PINS; i++) begin
      cand = IDX_W'(ptr + IDX_W'(i) + 1'b1);
      if (!any && pend[cand]) begin
        any   = 1'b1;
        grant = cand;
      end
    end
  end

  always_comb begin
    pop = '0;
    if (load && any) pop[grant] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid <= 1'b0;
      msg_kind  <= 1'b0;
      msg_pin   <= '0;
      ptr       <= IDX_W'(NUM_PINS - 1);
    end else if (load) begin
      msg_valid <= any;
      if (any) begin
        msg_kind <= kind[grant];
        msg_pin  <= idx_to_code(grant);
        ptr      <= grant;
      end
    end
  end

  // R7: an offered message stays put until taken
  p_hold_stable_r7: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_kind) && $stable(msg_pin)));

  // R3: only defined wire codes leave the block
  p_pin_code_r3: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> (msg_pin >= 3'd1 && msg_pin <= 3'd4));
endmodule

// File: rtl/lim_cfg_read.sv
module lim_cfg_read
  import lim_pkg::*;
#(
  parameter int NUM_FUNC = 2,
  parameter logic [PIN_W*NUM_FUNC-1:0]  FUNC_PIN  = {3'd1, 3'd1},
  parameter logic [LINE_W*NUM_FUNC-1:0] FUNC_LINE = {8'hFF, 8'd5},
  parameter int SEL_W = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] cfg_sel,
  output logic [CFG_W-1:0] cfg_rdata
);
  localparam int PAD_W = CFG_W - PIN_W - LINE_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
    end else begin
      cfg_rdata <= '0;
      for (int f = 0; f < NUM_FUNC; f++) begin
        if (cfg_sel == SEL_W'(f))
          cfg_rdata <= {{PAD_W{1'b0}}, FUNC_PIN[PIN_W*f +: PIN_W],
                        FUNC_LINE[LINE_W*f +: LINE_W]};
      end
    end
  end
endmodule

// File: rtl/lim_msg_gen.sv
module lim_msg_gen
  import lim_pkg::*;
#(
  parameter int NUM_FUNC   = 2,
  parameter int PEND_DEPTH = 4,
  parameter logic [PIN_W*NUM_FUNC-1:0]  FUNC_PIN  = {3'd1, 3'd1},
  parameter logic [LINE_W*NUM_FUNC-1:0] FUNC_LINE = {8'hFF, 8'd5},
  localparam int SEL_W = (NUM_FUNC > 1) ? $clog2(NUM_FUNC) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_FUNC-1:0] irq_req,
  input  logic [NUM_FUNC-1:0] irq_dis,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic                msg_kind,
  output logic [PIN_W-1:0]    msg_pin,
  input  logic [SEL_W-1:0]    cfg_sel,
  output logic [CFG_W-1:0]    cfg_rdata
);
  logic [NUM_PINS-1:0] pin_lvl;
  logic [NUM_PINS-1:0] pend;
  logic [NUM_PINS-1:0] kind;
  logic [NUM_PINS-1:0] pop;

  lim_req_stage #(
    .NUM_FUNC (NUM_FUNC),
    .FUNC_PIN (FUNC_PIN)
  ) u_req (
    .clk     (clk),
    .rst     (rst),
    .irq_req (irq_req),
    .irq_dis (irq_dis),
    .pin_lvl (pin_lvl)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    lim_pin_track #(
      .PEND_DEPTH (PEND_DEPTH)
    ) u_track (
      .clk       (clk),
      .rst       (rst),
      .lvl       (pin_lvl[p]),
      .pop       (pop[p]),
      .pend      (pend[p]),
      .next_kind (kind[p])
    );
  end

  lim_msg_out u_out (
    .clk       (clk),
    .rst       (rst),
    .pend      (pend),
    .kind      (kind),
    .pop       (pop),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .msg_kind  (msg_kind),
    .msg_pin   (msg_pin)
  );

  lim_cfg_read #(
    .NUM_FUNC  (NUM_FUNC),
    .FUNC_PIN  (FUNC_PIN),
    .FUNC_LINE (FUNC_LINE),
    .SEL_W     (SEL_W)
  ) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .cfg_sel   (cfg_sel),
    .cfg_rdata (cfg_rdata)
  );
endmodule

// File: tb/lim_msg_gen_bench.sv
module lim_msg_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // A: both functions share INTA; B: INTC and INTD; C: both codes invalid
  logic [1:0] a_req = '0, a_dis = '0, b_req = '0, b_dis = '0, c_req = '0, c_dis = '0;
  logic a_rdy = 1'b1, b_rdy = 1'b1, c_rdy = 1'b1;
  logic a_vld, b_vld, c_vld, a_kind, b_kind, c_kind;
  logic [2:0] a_pin, b_pin, c_pin;
  logic a_sel = 1'b0, b_sel = 1'b0, c_sel = 1'b0;
  logic [15:0] a_rd, b_rd, c_rd;

  lim_msg_gen #(.FUNC_PIN({3'd1, 3'd1}), .FUNC_LINE({8'hFF, 8'd5})) u_lim_msg_gen (
    .clk(clk), .rst(rst), .irq_req(a_req), .irq_dis(a_dis), .msg_valid(a_vld),
    .msg_ready(a_rdy), .msg_kind(a_kind), .msg_pin(a_pin), .cfg_sel(a_sel), .cfg_rdata(a_rd));
  lim_msg_gen #(.FUNC_PIN({3'd4, 3'd3}), .FUNC_LINE({8'd15, 8'd0})) u_lim_msg_gen_b (
    .clk(clk), .rst(rst), .irq_req(b_req), .irq_dis(b_dis), .msg_valid(b_vld),
    .msg_ready(b_rdy), .msg_kind(b_kind), .msg_pin(b_pin), .cfg_sel(b_sel), .cfg_rdata(b_rd));
  lim_msg_gen #(.FUNC_PIN({3'd5, 3'd0}), .FUNC_LINE({8'd2, 8'd1})) u_lim_msg_gen_c (
    .clk(clk), .rst(rst), .irq_req(c_req), .irq_dis(c_dis), .msg_valid(c_vld),
    .msg_ready(c_rdy), .msg_kind(c_kind), .msg_pin(c_pin), .cfg_sel(c_sel), .cfg_rdata(c_rd));

  // Scoreboard queues of expected message kinds, one per wire in use
  logic qa[$];
  logic qb3[$];
  logic qb4[$];

  task automatic set_a(input logic [1:0] r, input logic [1:0] d);
    logic was, now;
    was = |(a_req & ~a_dis);
    now = |(r & ~d);
    a_req = r; a_dis = d;
    if (now != was) qa.push_back(now);
  endtask

  task automatic drive_a(input logic [1:0] r, input logic [1:0] d);
    @(negedge clk);
    set_a(r, d);
  endtask

  task automatic drive_b(input logic [1:0] r, input logic [1:0] d);
    logic w3, w4;
    @(negedge clk);
    w3 = b_req[0] & ~b_dis[0];
    w4 = b_req[1] & ~b_dis[1];
    b_req = r; b_dis = d;
    if ((r[0] & ~d[0]) != w3) qb3.push_back(r[0] & ~d[0]);
    if ((r[1] & ~d[1]) != w4) qb4.push_back(r[1] & ~d[1]);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_all(input logic s, input logic [15:0] ea, input logic [15:0] eb,
                        input logic [15:0] ec);
    @(negedge clk);
    a_sel = s; b_sel = s; c_sel = s;
    @(negedge clk);
    chk(a_rd == ea, "R10", "cfg word A", a_rd, ea);
    chk(b_rd == eb, "R10", "cfg word B", b_rd, eb);
    chk(c_rd == ec, "R10", "cfg word C (invalid codes read raw)", c_rd, ec);
  endtask

  // Monitors: sample between the falling edge and the next rising edge
  always begin
    logic e;
    @(negedge clk); #1;
    if (!rst && a_vld && a_rdy) begin
      if (qa.size() == 0) chk(1'b0, "R4", "unexpected message on shared wire", a_kind, -1);
      else begin
        e = qa.pop_front();
        chk(a_kind == e, "R1 R2", "shared wire kind", a_kind, e);
        chk(a_pin == 3'b001, "R3", "shared wire code", a_pin, 1);
      end
    end
  end

  always begin
    logic e;
    @(negedge clk); #1;
    if (!rst && b_vld && b_rdy) begin
      if (b_pin == 3'b011 && qb3.size() != 0) begin
        e = qb3.pop_front();
        chk(b_kind == e, "R5", "INTC kind", b_kind, e);
      end else if (b_pin == 3'b100 && qb4.size() != 0) begin
        e = qb4.pop_front();
        chk(b_kind == e, "R5", "INTD kind", b_kind, e);
      end else chk(1'b0, "R3", "unexpected code or message on B", b_pin, -1);
    end
  end

  int c_msgs = 0;
  always begin
    @(negedge clk); #1;
    if (!rst && c_vld) c_msgs++;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      chk(1'b0, "R7", "watchdog expired", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic hk;
    logic [2:0] hp;
    // R11: reset holds the slot empty; B's INTC request is held across release
    b_req = 2'b01;
    idle(3);
    chk(a_vld == 1'b0 && b_vld == 1'b0, "R11", "valid during reset", a_vld, 0);
    qb3.push_back(1'b1);
    @(negedge clk); rst = 1'b0;
    idle(2);
    chk(a_vld == 1'b0, "R11", "shared wire idle after reset", a_vld, 0);
    idle(6);

    // R10: configuration readback for both functions
    rd_all(1'b0, 16'h0105, 16'h0300, 16'h0001);
    rd_all(1'b1, 16'h01FF, 16'h040F, 16'h0502);

    // R1 R4 R2: shared wire, overlapping requests
    drive_a(2'b01, 2'b00); idle(6);
    drive_a(2'b11, 2'b00); idle(6);
    drive_a(2'b10, 2'b00); idle(6);
    drive_a(2'b00, 2'b00); idle(6);

    // R9: disable pulls a contribution out of the aggregate
    drive_a(2'b01, 2'b00); idle(4);
    drive_a(2'b01, 2'b01); idle(4);
    drive_a(2'b01, 2'b00); idle(4);
    drive_a(2'b11, 2'b00); idle(4);
    drive_a(2'b11, 2'b10); idle(4);
    drive_a(2'b11, 2'b11); idle(4);
    drive_a(2'b00, 2'b00); idle(6);

    // R7 R8: stalled burst of four changes, then release
    @(negedge clk); a_rdy = 1'b0;
    drive_a(2'b01, 2'b00);
    drive_a(2'b00, 2'b00);
    drive_a(2'b01, 2'b00);
    drive_a(2'b00, 2'b00);
    idle(4);
    chk(a_vld == 1'b1, "R7", "message offered while stalled", a_vld, 1);
    hk = a_kind; hp = a_pin;
    idle(3);
    chk(a_kind == hk && a_pin == hp, "R7", "held kind/pin under stall", {a_kind, a_pin}, {hk, hp});
    @(negedge clk); a_rdy = 1'b1;
    idle(12);

    // R7: throttled ready with sparse toggles
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      a_rdy = (i % 3 != 0);
      if (i % 2 == 0) set_a({1'b0, ~a_req[0]}, 2'b00);
    end
    @(negedge clk); a_rdy = 1'b1;
    drive_a(2'b00, 2'b00); idle(10);

    // R5 R9: separate wires, simultaneous changes
    drive_b(2'b11, 2'b00); idle(6);
    drive_b(2'b00, 2'b00); idle(6);
    drive_b(2'b11, 2'b00); idle(6);
    drive_b(2'b11, 2'b10); idle(6);
    drive_b(2'b00, 2'b00); idle(6);

    // R6: invalid codes on instance C
    @(negedge clk); c_req = 2'b11;
    idle(3);
    @(negedge clk); c_req = 2'b00;
    idle(3);
    @(negedge clk); c_req = 2'b01;
    idle(6);

    idle(20);
    chk(c_msgs == 0, "R6", "messages from invalid codes", c_msgs, 0);
    chk(qa.size() == 0, "R7", "shared wire messages left undelivered", qa.size(), 0);
    chk(qb3.size() == 0 && qb4.size() == 0, "R5", "separate wire messages left undelivered",
        qb3.size() + qb4.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule